// File: doc/BRIEF.md
# Truth-Table Predicate Mask Logic Unit

This block combines two predicate mask words, `src1` and `src2`, bit by bit under a 4-bit function code. The code is not an opcode. It is the truth table of the wanted two-input Boolean function. For every bit position `i`, the result bit is `funcCode[{src1[i], src2[i]}]`: the `src1` bit forms the upper index bit and the `src2` bit forms the lower one. One datapath therefore covers all sixteen functions of two inputs. These include clear, set, copy, invert, AND, OR, XOR, their complements, and the AND/OR-with-complement forms.

A caller presents both words and a code, and raises `inValid` for one cycle. On the next clock edge the unit registers the result word and raises `outValid`. The result holds its value until the next accepted strobe. A synchronous reset clears the result and the valid flag. The word width is a parameter.

Top module: `tmlu_top`

## Requirements
- R1: While `rst` is high at a rising edge, `result` becomes all zeros and `outValid` becomes 0 after that edge.
- R2: `outValid` after a rising edge equals the `inValid` sampled at that edge (one cycle of latency) when not in reset.
- R3: When `inValid` is high at an edge, `result` after that edge has bit i = `funcCode[{src1[i],src2[i]}]`, where code bit 3 is the result for (1,1), bit 2 for src1=1/src2=0, bit 1 for src1=0/src2=1, and bit 0 for (0,0).
- R4: When `inValid` is low at an edge, `result` keeps its previous value, whatever `src1`, `src2` and `funcCode` carry.
- R5: Code 4'h0 yields all zeros and code 4'hF yields all ones, regardless of the operands.
- R6: Code 4'hC copies src1, 4'h3 inverts src1, 4'hA copies src2, and 4'h5 inverts src2.
- R7: Code 4'h8 gives AND, 4'hE gives OR, 4'h6 gives XOR, 4'h9 gives XNOR, 4'h7 gives NAND, and 4'h1 gives NOR.
- R8: Code 4'h4 gives src1 AND NOT src2, 4'h2 gives src2 AND NOT src1, 4'hD gives src1 OR NOT src2, and 4'hB gives src2 OR NOT src1.
- R9: Strobes on consecutive cycles each produce their own result, one cycle after their own edge, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operand/code strobe |
| src1 | input | XLEN | First mask word (upper truth-table index bit) |
| src2 | input | XLEN | Second mask word (lower truth-table index bit) |
| funcCode | input | 4 | Truth table of the function |
| outValid | output | 1 | Result word is fresh |
| result | output | XLEN | Registered result word |

## Verification
Every result and its `outValid` flag are due exactly one clock after the edge that samples `inValid`. The bench drives inputs at a falling edge, lets one rising edge capture them, and compares at the next falling edge. Hold checks drop the strobe, change every other input, and compare `result` at the falling edge after the following rising edge. Back-to-back strobes are checked at successive falling edges, so a result that arrives one cycle late or early shows up as a mismatch.

// File: rtl/tmlu_pkg.sv
package tmlu_pkg;

  localparam int unsigned TT_BITS = 4;

  typedef struct packed {
    logic capture;
    logic flush;
  } tmluStrobes_t;

endpackage

// File: rtl/tmlu_ctrl.sv
module tmlu_ctrl
  import tmlu_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output tmluStrobes_t strobes,
  output logic         outValid
);

  always_comb begin
    strobes.flush   = rst;
    strobes.capture = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  AST_RESET_VALID: assert property (@(posedge clk) rst |=> !outValid); // R1
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst) inValid |=> outValid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst) !inValid |=> !outValid); // R2

endmodule

// File: rtl/tmlu_datapath.sv
module tmlu_datapath
  import tmlu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic               clk,
  input  tmluStrobes_t       strobes,
  input  logic [XLEN-1:0]    src1,
  input  logic [XLEN-1:0]    src2,
  input  logic [TT_BITS-1:0] funcCode,
  output logic [XLEN-1:0]    result
);

  localparam logic [XLEN-1:0] ALL_ONES = {XLEN{1'b1}};

  logic [XLEN-1:0] nextWord;

  // One truth-table lookup per bit lane.
  for (genvar gi = 0; gi < XLEN; gi++) begin : gLane
    assign nextWord[gi] = funcCode[{src1[gi], src2[gi]}];
  end

  always_ff @(posedge clk) begin
    if (strobes.flush)        result <= '0;
    else if (strobes.capture) result <= nextWord;
  end

  AST_RESET_RESULT: assert property (@(posedge clk) strobes.flush |=> (result == '0)); // R1
  AST_HOLD: assert property (@(posedge clk) disable iff (strobes.flush) !strobes.capture |=> $stable(result)); // R4
  AST_CLEAR_CODE: assert property (@(posedge clk) disable iff (strobes.flush) (strobes.capture && funcCode == 4'h0) |=> (result == '0)); // R5
  AST_SET_CODE: assert property (@(posedge clk) disable iff (strobes.flush) (strobes.capture && funcCode == 4'hF) |=> (result == ALL_ONES)); // R5
  AST_AND_CODE: assert property (@(posedge clk) disable iff (strobes.flush) (strobes.capture && funcCode == 4'h8) |=> (result == ($past(src1) & $past(src2)))); // R7
  AST_COPY1_CODE: assert property (@(posedge clk) disable iff (strobes.flush) (strobes.capture && funcCode == 4'hC) |=> (result == $past(src1))); // R6

endmodule

// File: rtl/tmlu_top.sv
module tmlu_top
  import tmlu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [XLEN-1:0]    src1,
  input  logic [XLEN-1:0]    src2,
  input  logic [TT_BITS-1:0] funcCode,
  output logic               outValid,
  output logic [XLEN-1:0]    result
);

  tmluStrobes_t strobes;

  tmlu_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  tmlu_datapath #(.XLEN(XLEN)) uData (
    .clk      (clk),
    .strobes  (strobes),
    .src1     (src1),
    .src2     (src2),
    .funcCode (funcCode),
    .result   (result)
  );

endmodule

// File: tb/tb_tmlu_top.sv
module tb_tmlu_top;

  localparam int unsigned XLEN = 32;
  localparam int unsigned NPAT = 6;
  localparam logic [XLEN-1:0] PAT_A [NPAT] = '{32'hFF00FF00, 32'h00000000, 32'hFFFFFFFF,
                                                32'h12345678, 32'hAAAAAAAA, 32'hFFFFFFFF};
  localparam logic [XLEN-1:0] PAT_B [NPAT] = '{32'hF0F0F0F0, 32'h00000000, 32'h00000000,
                                                32'h9ABCDEF0, 32'h55555555, 32'hFFFFFFFF};

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            inValid = 1'b0;
  logic [XLEN-1:0] src1 = '0;
  logic [XLEN-1:0] src2 = '0;
  logic [3:0]      funcCode = '0;
  logic            outValid;
  logic [XLEN-1:0] result;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10ns clk = ~clk;

  tmlu_top #(.XLEN(XLEN)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .src1(src1), .src2(src2),
    .funcCode(funcCode), .outValid(outValid), .result(result)
  );

  function automatic logic [XLEN-1:0] refOp(input logic [3:0] c, input logic [XLEN-1:0] a,
                                            input logic [XLEN-1:0] b);
    case (c)
      4'h0: refOp = '0;
      4'h1: refOp = ~(a | b);
      4'h2: refOp = ~a & b;
      4'h3: refOp = ~a;
      4'h4: refOp = a & ~b;
      4'h5: refOp = ~b;
      4'h6: refOp = a ^ b;
      4'h7: refOp = ~(a & b);
      4'h8: refOp = a & b;
      4'h9: refOp = ~(a ^ b);
      4'hA: refOp = b;
      4'hB: refOp = ~a | b;
      4'hC: refOp = a;
      4'hD: refOp = a | ~b;
      4'hE: refOp = a | b;
      default: refOp = '1;
    endcase
  endfunction

  function automatic string reqOf(input logic [3:0] c);
    case (c)
      4'h0, 4'hF:             reqOf = "R5";
      4'h3, 4'h5, 4'hA, 4'hC: reqOf = "R6";
      4'h2, 4'h4, 4'hB, 4'hD: reqOf = "R8";
      default:                reqOf = "R7";
    endcase
  endfunction

  task automatic checkWord(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive at a falling edge, capture at the rising edge, check at the next falling edge.
  task automatic applyOp(input logic [3:0] c, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    @(negedge clk);
    funcCode = c; src1 = a; src2 = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkWord({reqOf(c), "/R3"}, result, refOp(c, a, b));
    checkBit("R2", outValid, 1'b1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [XLEN-1:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkWord("R1", result, '0);
    checkBit("R1", outValid, 1'b0);
    rst = 1'b0;

    // Every code across every operand pattern (R3, R5..R8)
    for (int p = 0; p < NPAT; p++) begin
      for (int c = 0; c < 16; c++) begin
        applyOp(4'(c), PAT_A[p], PAT_B[p]);
      end
    end

    // R4: result holds and outValid drops without a strobe
    applyOp(4'h6, 32'hDEADBEEF, 32'h0F0F0F0F);
    held = 32'hDEADBEEF ^ 32'h0F0F0F0F;
    funcCode = 4'hF; src1 = 32'h13579BDF; src2 = 32'h2468ACE0;
    @(negedge clk);
    checkWord("R4", result, held);
    checkBit("R2", outValid, 1'b0);
    funcCode = 4'h0;
    @(negedge clk);
    checkWord("R4", result, held);

    // R9: consecutive strobes, one result per cycle
    @(negedge clk);
    funcCode = 4'h8; src1 = 32'hF0F0F0F0; src2 = 32'hFF00FF00; inValid = 1'b1;
    @(negedge clk);
    checkWord("R9", result, 32'hF000F000);
    checkBit("R9", outValid, 1'b1);
    funcCode = 4'hE; src1 = 32'h00000001; src2 = 32'h80000000;
    @(negedge clk);
    checkWord("R9", result, 32'h80000001);
    checkBit("R9", outValid, 1'b1);
    funcCode = 4'h3; src1 = 32'h0000FFFF; src2 = 32'h12345678;
    @(negedge clk);
    inValid = 1'b0;
    checkWord("R9", result, 32'hFFFF0000);
    checkBit("R9", outValid, 1'b1);

    // R1: reset mid-run with a strobe present
    applyOp(4'hF, 32'h0, 32'h0);
    rst = 1'b1; inValid = 1'b1;
    @(negedge clk);
    checkWord("R1", result, '0);
    checkBit("R1", outValid, 1'b0);
    rst = 1'b0; inValid = 1'b0;
    @(negedge clk);
    checkWord("R1", result, '0);
    checkBit("R2", outValid, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule